// File: doc/BRIEF.md
# USB Device Bus Event Status Unit

This block holds the device-side status and control state that reacts to two events on the USB bus. The first is a bus reset driven by the host. The second is a start-of-frame (SOF) token. A token decoder upstream reports these as single-cycle pulses: reset begin, reset end, SOF seen, the 11-bit frame number and a flag for a CRC or bit-stuff error. The block stores the device address, the current frame number with its error bit, a configuration byte per endpoint, the endpoint interrupt enables and flags, the two stall requests per endpoint and the upstream-resume request. It also stores the enables and flags for the device-level interrupts.

While a bus reset is in progress, the block clears the state that must return to default and leaves endpoint 0's configuration as it was. No firmware action is needed. When the reset ends, the block raises an end-of-reset flag. Firmware programs the state through a simple one-cycle write port and clears flags by writing ones to them. A single interrupt line combines the enabled device flags. A per-endpoint summary shows which endpoints hold an enabled flag. Transaction logic sets the endpoint flags with one-cycle pulses.

Top module: `usb_bus_event_status`

## Requirements
- R1: After `rst_n` is low, every output is 0.
- R2: A bus reset is busy in the cycle of `bus_rst_start` and in every later cycle up to and including the cycle of `bus_rst_end`. While it is busy, the configuration of every endpoint except endpoint 0 is forced to 0. Endpoint 0's configuration is not touched by the reset and can still be written.
- R3: While a bus reset is busy, the device address, the frame number, the frame error bit, the endpoint interrupt enables, both stall bits of every endpoint and the upstream-resume bit are held at 0. A firmware write to any of them in those cycles has no effect.
- R4: A `bus_rst_end` pulse while a reset is busy (and without a new `bus_rst_start`) sets the end-of-reset flag, `dev_flags[0]`, in the next cycle and ends the busy state.
- R5: An SOF pulse outside a bus reset stores `sof_frame` into `frame_num` in the next cycle. An SOF pulse always sets the SOF flag, `dev_flags[1]`.
- R6: On every stored SOF, `fn_err` takes the value of `sof_err`, so a later SOF without error clears it.
- R7: Flags are cleared by writing 1 to them. `wr_sel`=3 clears device flag i when `wr_data[i]` is 1. `wr_sel`=6 clears the flags of endpoint `wr_ep` where `wr_data` has ones. If hardware sets a flag in the same cycle as the clear, the flag ends up set. Bits of `ep_flag_set` at [e*8 +: 8] set the flags of endpoint e.
- R8: `irq` is 1 exactly when some device flag and its enable (`dev_int_en`, same bit position) are both 1.
- R9: `ep_summary[e]` is 1 exactly when endpoint e has some flag whose enable bit is also 1.
- R10: The write port updates state in the next cycle according to `wr_sel`:
  - 0: address = `wr_data[6:0]`
  - 1: upstream resume = `wr_data[0]`
  - 2: device enables = `wr_data[1:0]`
  - 4: configuration of `wr_ep` = `wr_data`
  - 5: interrupt enables of `wr_ep` = `wr_data`
  - 7: stall bank 0 of `wr_ep` = `wr_data[0]` and stall bank 1 = `wr_data[1]`
- R11: A bus reset leaves the device interrupt enables and the device flags unchanged, apart from the end-of-reset flag being set at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_start | input | 1 | Pulse: host bus reset has begun |
| bus_rst_end | input | 1 | Pulse: host bus reset has finished |
| sof_seen | input | 1 | Pulse: SOF token decoded |
| sof_frame | input | 11 | Frame number carried by the SOF token |
| sof_err | input | 1 | SOF token had a CRC or bit-stuff error |
| ep_flag_set | input | 64 | Per-endpoint flag set pulses, 8 bits per endpoint |
| wr_en | input | 1 | Firmware write strobe |
| wr_sel | input | 3 | Write target select |
| wr_ep | input | 3 | Endpoint index for endpoint targets |
| wr_data | input | 8 | Write data |
| dev_addr | output | 7 | Device address |
| up_resume | output | 1 | Upstream-resume request |
| frame_num | output | 11 | Last stored frame number |
| fn_err | output | 1 | Error bit of the last stored SOF |
| dev_int_en | output | 2 | Device interrupt enables {SOF, end-of-reset} |
| dev_flags | output | 2 | Device flags {SOF, end-of-reset} |
| ep_cfg | output | 64 | Endpoint configurations, 8 bits per endpoint |
| ep_int_en | output | 64 | Endpoint interrupt enables |
| ep_int_flag | output | 64 | Endpoint interrupt flags |
| ep_stall0 | output | 8 | Bank 0 stall request per endpoint |
| ep_stall1 | output | 8 | Bank 1 stall request per endpoint |
| ep_summary | output | 8 | Per-endpoint enabled-flag summary |
| irq | output | 1 | Device interrupt |
| bus_rst_active | output | 1 | A bus reset is in progress |

## Verification
The bench drives firmware writes in the same cycles as a bus reset is busy, including its first and last cycle. A design that lets a write through there, or that clears endpoint 0 along with the other endpoints, diverges from the model at once. A flag clear that lands in the same cycle as a hardware set is checked as well: a design that lets the clear win loses the event. The bench sends an SOF with an error followed by one without, which catches an error bit that is only ever set. A long random mix of resets, SOFs, writes and set pulses then looks for ordering faults, such as end-of-reset being set without a preceding start, or the device enables being cleared by a reset.

// File: rtl/usb_bus_event_status.sv
module usb_bus_event_status #(
  parameter int NUM_EP = 8,
  parameter int ADDR_W = 7,
  parameter int FN_W   = 11,
  parameter int CFG_W  = 8,
  parameter int EPF_W  = 8,
  parameter int DATA_W = 8,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rst_start,
  input  logic                    bus_rst_end,
  input  logic                    sof_seen,
  input  logic [FN_W-1:0]         sof_frame,
  input  logic                    sof_err,
  input  logic [NUM_EP*EPF_W-1:0] ep_flag_set,
  input  logic                    wr_en,
  input  logic [2:0]              wr_sel,
  input  logic [EP_W-1:0]         wr_ep,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [ADDR_W-1:0]       dev_addr,
  output logic                    up_resume,
  output logic [FN_W-1:0]         frame_num,
  output logic                    fn_err,
  output logic [1:0]              dev_int_en,
  output logic [1:0]              dev_flags,
  output logic [NUM_EP*CFG_W-1:0] ep_cfg,
  output logic [NUM_EP*EPF_W-1:0] ep_int_en,
  output logic [NUM_EP*EPF_W-1:0] ep_int_flag,
  output logic [NUM_EP-1:0]       ep_stall0,
  output logic [NUM_EP-1:0]       ep_stall1,
  output logic [NUM_EP-1:0]       ep_summary,
  output logic                    irq,
  output logic                    bus_rst_active
);

  localparam logic [2:0] SEL_ADDR   = 3'd0;
  localparam logic [2:0] SEL_CTRL   = 3'd1;
  localparam logic [2:0] SEL_DEVEN  = 3'd2;
  localparam logic [2:0] SEL_DEVCLR = 3'd3;
  localparam logic [2:0] SEL_EPCFG  = 3'd4;
  localparam logic [2:0] SEL_EPEN   = 3'd5;
  localparam logic [2:0] SEL_EPCLR  = 3'd6;
  localparam logic [2:0] SEL_STALL  = 3'd7;

  logic       busy;
  logic [1:0] dev_set, dev_clr;

  assign busy    = bus_rst_start | bus_rst_active;
  assign dev_set = {sof_seen, bus_rst_end & bus_rst_active & ~bus_rst_start};
  assign dev_clr = (wr_en && wr_sel == SEL_DEVCLR) ? wr_data[1:0] : 2'b00;
  assign irq     = |(dev_flags & dev_int_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             bus_rst_active <= 1'b0;
    else if (bus_rst_start) bus_rst_active <= 1'b1;
    else if (bus_rst_end)   bus_rst_active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr  <= '0;
      up_resume <= 1'b0;
    end else if (busy) begin
      dev_addr  <= '0;
      up_resume <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel == SEL_ADDR) dev_addr  <= wr_data[ADDR_W-1:0];
      if (wr_sel == SEL_CTRL) up_resume <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_num <= '0;
      fn_err    <= 1'b0;
    end else if (busy) begin
      frame_num <= '0;
      fn_err    <= 1'b0;
    end else if (sof_seen) begin
      frame_num <= sof_frame;
      fn_err    <= sof_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_int_en <= 2'b00;
      dev_flags  <= 2'b00;
    end else begin
      if (wr_en && wr_sel == SEL_DEVEN) dev_int_en <= wr_data[1:0];
      dev_flags <= (dev_flags & ~dev_clr) | dev_set;
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit;
    logic [EPF_W-1:0] clr;
    assign hit = wr_en && (wr_ep == EP_W'(e));
    assign clr = (hit && wr_sel == SEL_EPCLR) ? wr_data[EPF_W-1:0] : '0;
    assign ep_summary[e] = |(ep_int_flag[e*EPF_W +: EPF_W] & ep_int_en[e*EPF_W +: EPF_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ep_cfg[e*CFG_W +: CFG_W] <= '0;
      else if (e != 0 && busy)             ep_cfg[e*CFG_W +: CFG_W] <= '0;
      else if (hit && wr_sel == SEL_EPCFG) ep_cfg[e*CFG_W +: CFG_W] <= wr_data[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ep_int_en[e*EPF_W +: EPF_W]   <= '0;
        ep_int_flag[e*EPF_W +: EPF_W] <= '0;
        ep_stall0[e]                  <= 1'b0;
        ep_stall1[e]                  <= 1'b0;
      end else if (busy) begin
        ep_int_en[e*EPF_W +: EPF_W]   <= '0;
        ep_int_flag[e*EPF_W +: EPF_W] <= '0;
        ep_stall0[e]                  <= 1'b0;
        ep_stall1[e]                  <= 1'b0;
      end else begin
        if (hit && wr_sel == SEL_EPEN) ep_int_en[e*EPF_W +: EPF_W] <= wr_data[EPF_W-1:0];
        if (hit && wr_sel == SEL_STALL) begin
          ep_stall0[e] <= wr_data[0];
          ep_stall1[e] <= wr_data[1];
        end
        ep_int_flag[e*EPF_W +: EPF_W] <= (ep_int_flag[e*EPF_W +: EPF_W] & ~clr)
                                         | ep_flag_set[e*EPF_W +: EPF_W];
      end
    end
  end

endmodule

module usb_bus_event_status_chk #(
  parameter int NUM_EP = 8,
  parameter int ADDR_W = 7,
  parameter int FN_W   = 11,
  parameter int CFG_W  = 8,
  parameter int DATA_W = 8,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_rst_start,
  input logic                    bus_rst_end,
  input logic                    sof_seen,
  input logic [FN_W-1:0]         sof_frame,
  input logic                    sof_err,
  input logic                    wr_en,
  input logic [2:0]              wr_sel,
  input logic [EP_W-1:0]         wr_ep,
  input logic [DATA_W-1:0]       wr_data,
  input logic [ADDR_W-1:0]       dev_addr,
  input logic                    up_resume,
  input logic [FN_W-1:0]         frame_num,
  input logic                    fn_err,
  input logic [1:0]              dev_int_en,
  input logic [1:0]              dev_flags,
  input logic [NUM_EP*CFG_W-1:0] ep_cfg,
  input logic [NUM_EP-1:0]       ep_stall0,
  input logic [NUM_EP-1:0]       ep_stall1,
  input logic                    bus_rst_active
);
  logic in_rst;
  assign in_rst = bus_rst_start | bus_rst_active;

  AST_EP0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst && !(wr_en && wr_sel == 3'd4 && wr_ep == '0) |=> $stable(ep_cfg[CFG_W-1:0])); // R2
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> (dev_addr == '0 && ep_stall0 == '0 && ep_stall1 == '0 && !up_resume && frame_num == '0)); // R3
  AST_EORST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_end && bus_rst_active && !bus_rst_start |=> dev_flags[0] && !bus_rst_active); // R4
  AST_SOF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen && !in_rst |=> frame_num == $past(sof_frame) && dev_flags[1]); // R5
  AST_SOF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    sof_seen && !in_rst |=> fn_err == $past(sof_err)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_flags[1] && !(wr_en && wr_sel == 3'd3 && wr_data[1]) |=> dev_flags[1]); // R7
  AST_DEVEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst && !(wr_en && wr_sel == 3'd2) |=> $stable(dev_int_en)); // R11
endmodule

bind usb_bus_event_status usb_bus_event_status_chk #(
  .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .FN_W(FN_W), .CFG_W(CFG_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_usb_bus_event_status.sv
`timescale 1ns/1ps
module tb_usb_bus_event_status;
  localparam int NE = 8;

  logic clk = 0, rst_n = 0;
  logic bus_rst_start = 0, bus_rst_end = 0, sof_seen = 0, sof_err = 0, wr_en = 0;
  logic [10:0] sof_frame = 0;
  logic [63:0] ep_flag_set = 0;
  logic [2:0] wr_sel = 0, wr_ep = 0;
  logic [7:0] wr_data = 0;

  logic [6:0] dev_addr; logic up_resume; logic [10:0] frame_num; logic fn_err;
  logic [1:0] dev_int_en, dev_flags;
  logic [63:0] ep_cfg, ep_int_en, ep_int_flag;
  logic [7:0] ep_stall0, ep_stall1, ep_summary;
  logic irq, bus_rst_active;

  usb_bus_event_status dut (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_addr = 0, m_res = 0, m_fn = 0, m_fe = 0, m_den = 0, m_dfl = 0, m_rst = 0;
  int m_cfg[NE], m_en[NE], m_fl[NE], m_s0[NE], m_s1[NE];
  initial for (int i = 0; i < NE; i++) begin m_cfg[i]=0; m_en[i]=0; m_fl[i]=0; m_s0[i]=0; m_s1[i]=0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr=0; m_res=0; m_fn=0; m_fe=0; m_den=0; m_dfl=0; m_rst=0;
      for (int i = 0; i < NE; i++) begin m_cfg[i]=0; m_en[i]=0; m_fl[i]=0; m_s0[i]=0; m_s1[i]=0; end
    end else begin
      int busy, eor, clr;
      busy = bus_rst_start || m_rst;
      eor  = bus_rst_end && m_rst && !bus_rst_start;
      clr  = (wr_en && wr_sel == 3) ? wr_data[1:0] : 0;
      m_dfl = (m_dfl & ~clr & 3) | (sof_seen ? 2 : 0) | (eor ? 1 : 0);
      if (wr_en && wr_sel == 2) m_den = wr_data[1:0];
      if (bus_rst_start) m_rst = 1; else if (bus_rst_end) m_rst = 0;
      if (busy) begin
        m_addr = 0; m_res = 0; m_fn = 0; m_fe = 0;
        for (int i = 0; i < NE; i++) begin
          if (i != 0) m_cfg[i] = 0;
          m_en[i]=0; m_fl[i]=0; m_s0[i]=0; m_s1[i]=0;
        end
        if (wr_en && wr_sel == 4 && wr_ep == 0) m_cfg[0] = wr_data;
      end else begin
        if (sof_seen) begin m_fn = sof_frame; m_fe = sof_err; end
        if (wr_en && wr_sel == 0) m_addr = wr_data[6:0];
        if (wr_en && wr_sel == 1) m_res = wr_data[0];
        for (int i = 0; i < NE; i++) begin
          int c;
          c = (wr_en && wr_sel == 6 && wr_ep == i) ? wr_data : 0;
          m_fl[i] = (m_fl[i] & ~c & 255) | ep_flag_set[i*8 +: 8];
        end
        if (wr_en && wr_sel == 4) m_cfg[wr_ep] = wr_data;
        if (wr_en && wr_sel == 5) m_en[wr_ep] = wr_data;
        if (wr_en && wr_sel == 7) begin m_s0[wr_ep] = wr_data[0]; m_s1[wr_ep] = wr_data[1]; end
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] c, en, fl; logic [7:0] s0, s1, sm; bit ir;
    for (int i = 0; i < NE; i++) begin
      c[i*8 +: 8] = m_cfg[i]; en[i*8 +: 8] = m_en[i]; fl[i*8 +: 8] = m_fl[i];
      s0[i] = m_s0[i][0]; s1[i] = m_s1[i][0]; sm[i] = (m_fl[i] & m_en[i]) != 0;
    end
    ir = (m_dfl & m_den) != 0;
    chk("R2", "ep_cfg", ep_cfg, c);
    chk("R3", "dev_addr", dev_addr, m_addr);
    chk("R3", "up_resume", up_resume, m_res);
    chk("R3", "stall0", ep_stall0, s0);
    chk("R3", "stall1", ep_stall1, s1);
    chk("R4", "dev_flags", dev_flags, m_dfl);
    chk("R4", "bus_rst_active", bus_rst_active, m_rst);
    chk("R5", "frame_num", frame_num, m_fn);
    chk("R6", "fn_err", fn_err, m_fe);
    chk("R7", "ep_int_flag", ep_int_flag, fl);
    chk("R8", "irq", irq, ir);
    chk("R9", "ep_summary", ep_summary, sm);
    chk("R10", "ep_int_en", ep_int_en, en);
    chk("R11", "dev_int_en", dev_int_en, m_den);
  endtask

  task automatic idle();
    bus_rst_start = 0; bus_rst_end = 0; sof_seen = 0; sof_err = 0;
    wr_en = 0; ep_flag_set = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    if (rst_n) compare_all();
    idle();
  endtask

  task automatic wr(int sel, int ep, int d);
    wr_en = 1; wr_sel = sel[2:0]; wr_ep = ep[2:0]; wr_data = d[7:0];
  endtask

  task automatic sof(int f, int e);
    sof_seen = 1; sof_frame = f[10:0]; sof_err = e[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "outputs", {dev_addr, up_resume, frame_num, fn_err, dev_int_en, dev_flags, irq, bus_rst_active}, 0);
    chk("R1", "endpoint outputs", ep_cfg | ep_int_en | ep_int_flag | {ep_stall0, ep_stall1, ep_summary}, 0);
    // R10: program everything
    wr(0, 0, 8'h2a); tick();
    wr(1, 0, 1); tick();
    wr(2, 0, 3); tick();
    for (int i = 0; i < NE; i++) begin
      wr(4, i, 8'h11 * (i + 1)); tick();
      wr(5, i, 8'hf0 | i); tick();
      wr(7, i, 3); tick();
    end
    // R5, R6: SOF with error then without
    sof(11'h5a5, 1); tick();
    chk("R6", "fn_err after bad SOF", fn_err, 1);
    sof(11'h5a6, 0); tick();
    chk("R5", "frame after SOF", frame_num, 11'h5a6);
    chk("R6", "fn_err cleared by good SOF", fn_err, 0);
    // R7: set wins over simultaneous clear
    ep_flag_set[3*8 +: 8] = 8'h81; tick();
    chk("R9", "summary ep3", ep_summary[3], 1);
    wr(6, 3, 8'h81); ep_flag_set[3*8 +: 8] = 8'h80; tick();
    chk("R7", "set beats clear", ep_int_flag[3*8 +: 8], 8'h80);
    wr(3, 0, 2); sof(7, 0); tick();
    chk("R7", "sof flag set beats clear", dev_flags[1], 1);
    wr(3, 0, 3); tick();
    chk("R8", "irq low after clears", irq, 0);
    // R2, R3: bus reset with writes during it
    bus_rst_start = 1; wr(4, 0, 8'h77); tick();
    wr(0, 0, 8'h55); tick();
    wr(4, 5, 8'h99); sof(3, 1); tick();
    wr(7, 2, 3); tick();
    bus_rst_end = 1; wr(1, 0, 1); tick();
    chk("R2", "ep0 kept and writable", ep_cfg[7:0], 8'h77);
    chk("R2", "ep5 cleared", ep_cfg[5*8 +: 8], 0);
    chk("R3", "address cleared", dev_addr, 0);
    chk("R4", "end-of-reset flag", dev_flags[0], 1);
    chk("R11", "enables kept", dev_int_en, 3);
    chk("R8", "irq with eorst", irq, 1);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) bus_rst_start = 1;
      else if (r < 8) bus_rst_end = 1;
      if ($urandom_range(0, 9) < 2) sof($urandom_range(0, 2047), $urandom_range(0, 1));
      if ($urandom_range(0, 9) < 5) wr($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 255));
      if ($urandom_range(0, 9) < 2) ep_flag_set = {$urandom, $urandom};
      tick();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule